// File: doc/BRIEF.md
# UART DMA Request Generator

This block raises the handshake requests a UART gives a DMA controller. It has one set for each direction, receive and transmit, and each set has a single-transfer request and a burst-transfer request. It watches the fill counts of the two 16-entry FIFOs. It compares them with a burst length chosen by a 3-bit watermark select for each direction. It then sets each request when that request's condition holds.

A request is sticky. It stays high until the DMA controller pulses the clear line for that direction, even if its condition has gone away in the meantime. Requests are forced low in these cases:
- the UART is disabled;
- the DMA enable for that direction is cleared;
- for burst requests only, the FIFOs are switched off.

The receive requests can also be held low while the receive error interrupt is active, if the DMA-on-error control bit is set. All requests are registered and change one clock after the inputs that cause them.

Top module: `uart_dma_req`

## Requirements
- R1: `rx_sreq` is high in the cycle after any clock edge at which `rx_count >= 1`, both `uart_en` and `rx_dma_en` are high, `rx_dma_clr` is low, and the error mask is not active.
- R2: `rx_breq` is set after an edge at which `fifo_en` is high and `rx_count` is at least the receive burst length. For `rx_wm_sel` codes 0, 1, 2, 3 and 4 that length is 2, 4, 8, 12 and 14. Any other code gives 8.
- R3: `tx_sreq` is set after an edge at which the transmit FIFO has at least one free slot. With `fifo_en` high this means `tx_count < 16`.
- R4: `tx_breq` is set after an edge at which `fifo_en` is high and `16 - tx_count` is at least the transmit burst length. For `tx_wm_sel` codes 0, 1, 2, 3 and 4 that length is 14, 12, 8, 4 and 2. Any other code gives 8.
- R5: A set request stays high while its gates stay open and its clear stays low, even after its condition goes away. The single and burst requests of a direction are independent and may both be high.
- R6: A clear that is high at an edge drives both requests of its direction low after that edge. They stay low while the clear is held. They may rise one cycle after the clear drops if their condition still holds.
- R7: With `fifo_en` low, both burst requests go low after the next edge and are never set. The FIFOs act as one-entry holders: the receive single condition is `rx_count >= 1` and the transmit single condition is `tx_count == 0`.
- R8: With `uart_en` low, every request is low after the next edge. With one direction's DMA enable low, both requests of that direction are low after the next edge.
- R9: While `dma_on_err` and `rx_err_irq` are both high, both receive requests are low after the next edge. The transmit requests are unaffected.
- R10: While `rst_n` is low, all four requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uart_en | input | 1 | UART enable |
| fifo_en | input | 1 | FIFO mode enable (low: one-entry holding mode) |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| dma_on_err | input | 1 | Mask receive requests while the error interrupt is active |
| rx_err_irq | input | 1 | Receive error interrupt |
| rx_wm_sel | input | 3 | Receive watermark select |
| tx_wm_sel | input | 3 | Transmit watermark select |
| rx_count | input | 5 | Receive FIFO fill count, 0 to 16 |
| tx_count | input | 5 | Transmit FIFO fill count, 0 to 16 |
| rx_dma_clr | input | 1 | Receive request clear from the DMA controller |
| tx_dma_clr | input | 1 | Transmit request clear from the DMA controller |
| rx_sreq | output | 1 | Receive single-transfer request |
| rx_breq | output | 1 | Receive burst-transfer request |
| tx_sreq | output | 1 | Transmit single-transfer request |
| tx_breq | output | 1 | Transmit burst-transfer request |

## Verification
The assertions assume that the fill counts never go above the FIFO depth and that every control input is a clean synchronous level sampled at the clock. They do not assume any ordering between a clear and the conditions. The stimulus drives every input on the falling edge and draws counts only from 0 to 16. It mixes directed sequences for each threshold code with random phases in which the clears, gates and error mask toggle freely within those bounds.

// File: rtl/uart_dmareq_pkg.sv
// Shared helpers for the UART DMA request generator.
// Assumes the watermark select is a 3-bit code. Codes 0..4 map to 1/8,
// 1/4, 1/2, 3/4 and 7/8. Every other code is treated as 1/2.
package uart_dmareq_pkg;

    typedef enum logic [2:0] {
        WM_EIGHTH    = 3'd0,
        WM_QUARTER   = 3'd1,
        WM_HALF      = 3'd2,
        WM_3QUARTER  = 3'd3,
        WM_7EIGHTH   = 3'd4
    } wm_sel_e;

    // Return the watermark fraction in eighths of the FIFO depth.
    function automatic int unsigned wm_eighths(input logic [2:0] sel);
        case (sel)
            WM_EIGHTH:   return 1;
            WM_QUARTER:  return 2;
            WM_HALF:     return 4;
            WM_3QUARTER: return 6;
            WM_7EIGHTH:  return 7;
            default:     return 4;
        endcase
    endfunction

endpackage

// File: rtl/uart_dmareq_cond.sv
// Condition decoder for one direction.
// For receive, the burst length is DEPTH*frac filled entries. For transmit,
// it is DEPTH - DEPTH*frac free entries. With fifo_en low the FIFO is
// treated as one entry deep, and the burst condition is forced low.
// Assumes count <= DEPTH.
module uart_dmareq_cond
    import uart_dmareq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter bit          IS_RX = 1'b1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [2:0]    wm_sel,
    input  logic          fifo_en,
    output logic          single_cond,
    output logic          burst_cond
);
    localparam int unsigned LW = CW + 1;

    logic [LW-1:0] level;   // filled entries needed (rx) or free entries needed (tx)
    logic [LW-1:0] free;    // free entries in full-depth mode

    // Derive the burst length for this direction from the watermark select.
    always_comb begin
        if (IS_RX) level = LW'((DEPTH * wm_eighths(wm_sel)) / 8);
        else       level = LW'(DEPTH - (DEPTH * wm_eighths(wm_sel)) / 8);
        free = LW'(DEPTH) - LW'(count);
    end

    generate
        if (IS_RX) begin : g_rx
            // The receive single condition is the same at either depth.
            always_comb begin
                single_cond = (count != '0);
                burst_cond  = fifo_en && (LW'(count) >= level);
            end
        end else begin : g_tx
            // The transmit single condition depends on the effective depth.
            always_comb begin
                single_cond = fifo_en ? (free != '0) : (count == '0);
                burst_cond  = fifo_en && (free >= level);
            end
        end
    endgenerate

endmodule

// File: rtl/uart_dmareq_chan.sv
// Sticky request pair for one direction.
// A request is set when its condition holds and is held until clr is seen.
// gate low clears both requests. burst_en low clears only the burst one.
// Assumes the inputs are synchronous to clk.
module uart_dmareq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic burst_en,
    input  logic clr,
    input  logic single_cond,
    input  logic burst_cond,
    output logic sreq,
    output logic breq
);
    // Hold or set the single request; clear it on clr or a closed gate.
    always_ff @(posedge clk) begin
        if (!rst_n)                sreq <= 1'b0;
        else if (!gate || clr)     sreq <= 1'b0;
        else if (single_cond)      sreq <= 1'b1;
    end

    // Same for the burst request, which also needs burst_en.
    always_ff @(posedge clk) begin
        if (!rst_n)                          breq <= 1'b0;
        else if (!gate || !burst_en || clr)  breq <= 1'b0;
        else if (burst_cond)                 breq <= 1'b1;
    end

endmodule

// File: rtl/uart_dma_req.sv
// UART DMA request generator: single and burst requests for each direction.
// Builds the per-direction gates (UART enable, DMA enable and, for receive,
// the error mask) and feeds a condition decoder and a sticky pair per side.
// Assumes the fill counts are at most DEPTH.
module uart_dma_req #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uart_en,
    input  logic          fifo_en,
    input  logic          rx_dma_en,
    input  logic          tx_dma_en,
    input  logic          dma_on_err,
    input  logic          rx_err_irq,
    input  logic [2:0]    rx_wm_sel,
    input  logic [2:0]    tx_wm_sel,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_dma_clr,
    input  logic          tx_dma_clr,
    output logic          rx_sreq,
    output logic          rx_breq,
    output logic          tx_sreq,
    output logic          tx_breq
);
    logic rx_gate, tx_gate;
    logic rx_sc, rx_bc, tx_sc, tx_bc;

    // Direction gates; the receive side is also masked by the error interrupt.
    always_comb begin
        rx_gate = uart_en && rx_dma_en && !(dma_on_err && rx_err_irq);
        tx_gate = uart_en && tx_dma_en;
    end

    uart_dmareq_cond #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_cond (
        .count(rx_count), .wm_sel(rx_wm_sel), .fifo_en(fifo_en),
        .single_cond(rx_sc), .burst_cond(rx_bc)
    );

    uart_dmareq_cond #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_cond (
        .count(tx_count), .wm_sel(tx_wm_sel), .fifo_en(fifo_en),
        .single_cond(tx_sc), .burst_cond(tx_bc)
    );

    uart_dmareq_chan u_rx_chan (
        .clk(clk), .rst_n(rst_n), .gate(rx_gate), .burst_en(fifo_en),
        .clr(rx_dma_clr), .single_cond(rx_sc), .burst_cond(rx_bc),
        .sreq(rx_sreq), .breq(rx_breq)
    );

    uart_dmareq_chan u_tx_chan (
        .clk(clk), .rst_n(rst_n), .gate(tx_gate), .burst_en(fifo_en),
        .clr(tx_dma_clr), .single_cond(tx_sc), .burst_cond(tx_bc),
        .sreq(tx_sreq), .breq(tx_breq)
    );

endmodule

// File: rtl/uart_dma_req_chk.sv
// Protocol checker for uart_dma_req, attached by bind.
// Assumes reset is held for at least one clock before release.
module uart_dma_req_chk (
    input logic clk,
    input logic rst_n,
    input logic uart_en,
    input logic fifo_en,
    input logic rx_dma_en,
    input logic tx_dma_en,
    input logic dma_on_err,
    input logic rx_err_irq,
    input logic rx_dma_clr,
    input logic tx_dma_clr,
    input logic rx_sreq,
    input logic rx_breq,
    input logic tx_sreq,
    input logic tx_breq
);
    p_clear_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_clr |=> (!rx_sreq && !rx_breq));

    p_clear_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_clr |=> (!tx_sreq && !tx_breq));

    p_uart_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_en |=> (!rx_sreq && !rx_breq && !tx_sreq && !tx_breq));

    p_dir_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_dma_en |=> (!rx_sreq && !rx_breq)) and (!tx_dma_en |=> (!tx_sreq && !tx_breq)));

    p_no_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> (!rx_breq && !tx_breq));

    p_err_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_on_err && rx_err_irq) |=> (!rx_sreq && !rx_breq));

    p_sticky_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sreq && uart_en && rx_dma_en && !(dma_on_err && rx_err_irq) && !rx_dma_clr)
        |=> rx_sreq);

    p_sticky_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_breq && uart_en && tx_dma_en && fifo_en && !tx_dma_clr) |=> tx_breq);

    // R10: the requests are low during reset.
    always @(negedge clk) begin
        if (!rst_n && $past(!rst_n))
            p_reset_r10: assert ({rx_sreq, rx_breq, tx_sreq, tx_breq} == 4'b0);
    end

endmodule

bind uart_dma_req uart_dma_req_chk u_chk (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .fifo_en(fifo_en),
    .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en), .dma_on_err(dma_on_err),
    .rx_err_irq(rx_err_irq), .rx_dma_clr(rx_dma_clr), .tx_dma_clr(tx_dma_clr),
    .rx_sreq(rx_sreq), .rx_breq(rx_breq), .tx_sreq(tx_sreq), .tx_breq(tx_breq)
);

// File: tb/uart_dma_req_test.sv
// Bench: a behavioural reference model advanced on each rising edge and
// compared on every falling edge, plus directed spot checks.
module uart_dma_req_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uart_en = 0, fifo_en = 0, rx_dma_en = 0, tx_dma_en = 0;
    logic dma_on_err = 0, rx_err_irq = 0, rx_dma_clr = 0, tx_dma_clr = 0;
    logic [2:0] rx_wm_sel = 0, tx_wm_sel = 0;
    logic [4:0] rx_count = 0, tx_count = 0;
    logic rx_sreq, rx_breq, tx_sreq, tx_breq;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R10";
    bit e_rs = 0, e_rb = 0, e_ts = 0, e_tb = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    uart_dma_req uut (.*);

    // Filled entries needed for a receive burst, taken from the requirement text.
    function automatic int rx_len(input int sel);
        case (sel) 0: return 2; 1: return 4; 2: return 8; 3: return 12; 4: return 14;
            default: return 8; endcase
    endfunction
    // Free entries needed for a transmit burst.
    function automatic int tx_len(input int sel);
        case (sel) 0: return 14; 1: return 12; 2: return 8; 3: return 4; 4: return 2;
            default: return 8; endcase
    endfunction

    // Reference model: the next expected requests, computed from the requirements.
    always @(posedge clk) begin
        bit rg, tg;
        int rc, tc;
        rc = int'(rx_count); tc = int'(tx_count);
        rg = uart_en && rx_dma_en && !(dma_on_err && rx_err_irq);
        tg = uart_en && tx_dma_en;
        if (!rst_n) begin
            e_rs = 0; e_rb = 0; e_ts = 0; e_tb = 0;
        end else begin
            e_rs = rg && !rx_dma_clr && (e_rs || rc >= 1);
            e_rb = rg && fifo_en && !rx_dma_clr && (e_rb || rc >= rx_len(int'(rx_wm_sel)));
            e_ts = tg && !tx_dma_clr && (e_ts || (fifo_en ? (tc < 16) : (tc == 0)));
            e_tb = tg && fifo_en && !tx_dma_clr && (e_tb || (16 - tc) >= tx_len(int'(tx_wm_sel)));
        end
        cycles++;
    end

    task automatic cmp(input string nm, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, nm, act, exp, $time);
        end
    endtask

    // Compare all four outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            cmp("rx_sreq", rx_sreq, e_rs);
            cmp("rx_breq", rx_breq, e_rb);
            cmp("tx_sreq", tx_sreq, e_ts);
            cmp("tx_breq", tx_breq, e_tb);
        end
    end

    task automatic spot(input string nm, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s spot %s actual=%b expected=%b", cur_req, nm, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        cur_req = "R10";
        spot("reset rx_sreq", rx_sreq, 0); spot("reset tx_breq", tx_breq, 0);
        rst_n = 1; uart_en = 1; fifo_en = 1; rx_dma_en = 1; tx_dma_en = 1;
        tx_count = 16; rx_count = 0;
        step(2);
        cur_req = "R1"; rx_count = 1; step(1);
        spot("rx single rises", rx_sreq, 1);
        // R2: sweep every receive watermark code around its threshold.
        cur_req = "R2";
        for (int s = 0; s < 8; s++) begin
            rx_dma_clr = 1; rx_wm_sel = 3'(s); rx_count = 5'(rx_len(s) - 1); step(1);
            rx_dma_clr = 0; step(2);
            spot("rx burst below", rx_breq, 0);
            rx_count = 5'(rx_len(s)); step(1);
            spot("rx burst at level", rx_breq, 1);
        end
        // R4: sweep every transmit watermark code; R3 at full and below.
        cur_req = "R4";
        for (int s = 0; s < 8; s++) begin
            tx_dma_clr = 1; tx_wm_sel = 3'(s); tx_count = 5'(16 - tx_len(s) + 1); step(1);
            tx_dma_clr = 0; step(2);
            spot("tx burst short", tx_breq, 0);
            tx_count = 5'(16 - tx_len(s)); step(1);
            spot("tx burst at level", tx_breq, 1);
        end
        cur_req = "R3"; tx_dma_clr = 1; tx_count = 16; step(1); tx_dma_clr = 0; step(2);
        spot("tx single full", tx_sreq, 0);
        tx_count = 15; step(1); spot("tx single free", tx_sreq, 1);
        // R5: sticky after the condition goes away.
        cur_req = "R5"; rx_count = 0; tx_count = 16; step(3);
        spot("rx single sticky", rx_sreq, 1); spot("tx single sticky", tx_sreq, 1);
        // R6: clear held, then released.
        cur_req = "R6"; rx_count = 5; rx_dma_clr = 1; step(3);
        spot("held clear", rx_sreq, 0);
        rx_dma_clr = 0; step(1); spot("rise after clear", rx_sreq, 1);
        // R7: FIFOs off.
        cur_req = "R7"; fifo_en = 0; rx_count = 1; tx_count = 1; tx_dma_clr = 1; step(1);
        tx_dma_clr = 0; step(2);
        spot("burst off", rx_breq, 0); spot("tx single one-entry busy", tx_sreq, 0);
        tx_count = 0; step(1); spot("tx single one-entry free", tx_sreq, 1);
        fifo_en = 1;
        // R9: error mask affects only the receive side.
        cur_req = "R9"; dma_on_err = 1; rx_err_irq = 1; step(2);
        spot("rx masked", rx_sreq, 0); spot("tx unaffected", tx_sreq, 1);
        rx_err_irq = 0; dma_on_err = 0; step(2);
        // R8: the enables.
        cur_req = "R8"; tx_dma_en = 0; step(1); spot("tx dma off", tx_sreq, 0);
        tx_dma_en = 1; uart_en = 0; step(1); spot("uart off", rx_sreq, 0);
        uart_en = 1;
        // Random phase across all requirements (the model compare covers R1..R9).
        cur_req = "R1..R9 random";
        for (int i = 0; i < 3000; i++) begin
            rx_count   = 5'($urandom_range(0, 16));
            tx_count   = 5'($urandom_range(0, 16));
            rx_wm_sel  = 3'($urandom_range(0, 7));
            tx_wm_sel  = 3'($urandom_range(0, 7));
            rx_dma_clr = ($urandom_range(0, 5) == 0);
            tx_dma_clr = ($urandom_range(0, 5) == 0);
            fifo_en    = ($urandom_range(0, 9) != 0);
            uart_en    = ($urandom_range(0, 19) != 0);
            rx_dma_en  = ($urandom_range(0, 14) != 0);
            tx_dma_en  = ($urandom_range(0, 14) != 0);
            dma_on_err = $urandom_range(0, 1) == 1;
            rx_err_irq = ($urandom_range(0, 7) == 0);
            step(1);
        end
        cur_req = "R10"; rst_n = 0; step(2);
        spot("reset again", rx_breq, 0); spot("reset again tx", tx_sreq, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule